// File: doc/BRIEF.md
# BCD Calendar Clock with Shadowed Register Set

This block keeps wall-clock time and calendar date as packed BCD bytes. It tracks century, year, month, date, day of week, hours (24-hour format), minutes and seconds. A hidden working set of counters advances once for each pulse on a one-second enable input. That input takes the place of the oscillator and its divider, which sit outside this block. Software never touches the working counters directly. It sees a second, user-visible copy that normally follows the working set on every clock cycle.

Software reaches the visible copy through a byte-wide register port that decodes the eight highest addresses of the address space. A read-hold bit freezes the visible copy so that several bytes can be read as one consistent snapshot, while the working counters keep running underneath. A load-hold bit also freezes the copy and lets software overwrite it with new time values. Clearing the load-hold bit pushes those values into the working counters in a single cycle. A run-stop bit, kept in the top bit of the seconds byte, halts timekeeping altogether and is set out of reset.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset, the control byte reads 0x20 (both hold bits clear, century 20), the seconds byte reads 0x80 (run-stop set, 00 seconds), minutes and hours read 00, and day, date and month read 01 with year 00.
- R2: While bit 7 of the seconds byte (run-stop) is 1, one-second pulses leave the working time unchanged. Any write to the seconds location updates run-stop from data bit 7, whether or not a hold bit is set.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23 in BCD. Each wrap carries into the next field, and an hour wrap advances the date and the day of week.
- R4: The day of week counts 01 to 07 and goes from 07 back to 01.
- R5: Months 04, 06, 09 and 11 end at date 30 and all other months except 02 end at date 31. At month end the date becomes 01 and the month advances, with month 12 going to 01 and the year advancing.
- R6: February ends at 29 when the year is divisible by 4 and not 00, or when the year is 00 and the century is divisible by 4. Otherwise it ends at 28.
- R7: Year 99 going to 00 advances the century.
- R8: The window starts at base 2^ADDR_W-8. The offsets are: 0 control (bit 7 load-hold, bit 6 read-hold, bits 5:0 century), 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Reads outside the window return 0, and writes outside it are ignored.
- R9: Setting the read-hold bit freezes every visible byte. After the bit is cleared, the visible bytes show the current working time on the next cycle.
- R10: While load-hold is set, writes to offsets 1 to 7 are stored unchanged without range checks, and a write to offset 0 that keeps load-hold set stores its century bits. While load-hold is clear, writes to offsets 2 to 7, and the time bits of offset 1, have no effect.
- R11: A control write that clears load-hold copies the visible time into the working counters, taking the century from that write's bits 5:0. A one-second pulse in that same cycle is discarded.
- R12: The working counters keep advancing while the read-hold bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| busSel | input | 1 | Access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |

## Verification
The bench uses the default parameters: a 13-bit address, which puts the window at 0x1FF8 to 0x1FFF, and a reset century of 20. The bench drives the one-second pulse directly, and the load-hold path places the working counters right at each boundary. Together these bring every rollover within a single pulse: the year-end cascade, month ends of 30 and 31 days, February in leap and non-leap years including the century-based year 00 case, and the year 99 to century carry. The same setup makes the collision of a pulse with a commit easy to reach.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  typedef struct packed {
    logic [5:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [6:0] sec;
  } calT;

  typedef struct packed {
    logic       freezeVis;
    logic       fieldWr;
    logic [2:0] fieldIdx;
    logic [7:0] wrData;
    logic       commit;
  } strobeT;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [1:0] bcdMod4(input logic [7:0] v);
    logic [5:0] s;
    s = {1'b0, v[7:4], 1'b0} + {2'b00, v[3:0]};
    return s[1:0];
  endfunction

  function automatic logic isLeap(input logic [7:0] yr, input logic [5:0] ce);
    if (yr == 8'h00) return bcdMod4({2'b00, ce}) == 2'd0;
    return bcdMod4(yr) == 2'd0;
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic calT nextCal(input calT c);
    calT n;
    logic [7:0] t;
    n = c;
    if (c.sec != 7'h59) begin
      t = bcdInc({1'b0, c.sec});
      n.sec = t[6:0];
    end else begin
      n.sec = 7'h00;
      if (c.min != 8'h59) n.min = bcdInc(c.min);
      else begin
        n.min = 8'h00;
        if (c.hour != 8'h23) n.hour = bcdInc(c.hour);
        else begin
          n.hour = 8'h00;
          n.day  = (c.day == 8'h07) ? 8'h01 : bcdInc(c.day);
          if (c.date != lastDay(c.month, isLeap(c.year, c.cent))) n.date = bcdInc(c.date);
          else begin
            n.date = 8'h01;
            if (c.month != 8'h12) n.month = bcdInc(c.month);
            else begin
              n.month = 8'h01;
              if (c.year != 8'h99) n.year = bcdInc(c.year);
              else begin
                n.year = 8'h00;
                t = bcdInc({2'b00, c.cent});
                n.cent = (c.cent == 6'h39) ? 6'h00 : t[5:0];
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/bcd_rtc_datapath.sv
module bcd_rtc_datapath
  import bcd_rtc_pkg::*;
#(
  parameter logic [5:0] RESET_CENT = 6'h20
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   secTick,
  input  logic   run,
  input  strobeT strb,
  output calT    visCal
);

  localparam calT RESET_CAL = '{cent: RESET_CENT, year: 8'h00, month: 8'h01, date: 8'h01,
                                day: 8'h01, hour: 8'h00, min: 8'h00, sec: 7'h00};

  calT intCal;
  calT commitCal;

  always_comb begin
    commitCal      = visCal;
    commitCal.cent = strb.wrData[5:0];
  end

  // working counters: commit wins over a same-cycle tick
  always_ff @(posedge clk) begin
    if (!rstN)                 intCal <= RESET_CAL;
    else if (strb.commit)      intCal <= commitCal;
    else if (secTick && run)   intCal <= nextCal(intCal);
  end

  // visible copy: follows working set unless frozen, loadable while frozen
  always_ff @(posedge clk) begin
    if (!rstN) visCal <= RESET_CAL;
    else if (!strb.freezeVis) visCal <= intCal;
    else if (strb.fieldWr) begin
      case (strb.fieldIdx)
        3'd0: visCal.cent  <= strb.wrData[5:0];
        3'd1: visCal.sec   <= strb.wrData[6:0];
        3'd2: visCal.min   <= strb.wrData;
        3'd3: visCal.hour  <= strb.wrData;
        3'd4: visCal.day   <= strb.wrData;
        3'd5: visCal.date  <= strb.wrData;
        3'd6: visCal.month <= strb.wrData;
        default: visCal.year <= strb.wrData;
      endcase
    end
  end

  // R9
  vis_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.freezeVis && !strb.fieldWr |=> visCal == $past(visCal));

  // R2
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run && !strb.commit |=> intCal == $past(intCal));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick && run && !strb.commit && intCal.sec == 7'h59 |=> intCal.sec == 7'h00);

  // R11
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> intCal.min == $past(visCal.min) && intCal.cent == $past(strb.wrData[5:0]));

endmodule

// File: rtl/bcd_rtc_control.sv
module bcd_rtc_control
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  calT               visCal,
  output logic [7:0]        busRdata,
  output strobeT            strb,
  output logic              run
);

  localparam int HI_W = ADDR_W - 3;

  logic       wrHalt, rdHalt, oscStop;
  logic       inWin, acc, wr, wrCtl;
  logic [2:0] off;

  assign off   = busAddr[2:0];
  assign inWin = &busAddr[ADDR_W-1:3];
  assign acc   = busSel && inWin;
  assign wr    = acc && busWe;
  assign wrCtl = wr && (off == 3'd0);
  assign run   = !oscStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrHalt  <= 1'b0;
      rdHalt  <= 1'b0;
      oscStop <= 1'b1;
    end else begin
      if (wrCtl) begin
        wrHalt <= busWdata[7];
        rdHalt <= busWdata[6];
      end
      if (wr && off == 3'd1) oscStop <= busWdata[7];
    end
  end

  always_comb begin
    strb.freezeVis = wrHalt || rdHalt;
    strb.fieldWr   = wr && wrHalt;
    strb.fieldIdx  = off;
    strb.wrData    = busWdata;
    strb.commit    = wrCtl && wrHalt && !busWdata[7];
  end

  always_comb begin
    busRdata = 8'h00;
    if (acc) begin
      case (off)
        3'd0: busRdata = {wrHalt, rdHalt, visCal.cent};
        3'd1: busRdata = {oscStop, visCal.sec};
        3'd2: busRdata = visCal.min;
        3'd3: busRdata = visCal.hour;
        3'd4: busRdata = visCal.day;
        3'd5: busRdata = visCal.date;
        3'd6: busRdata = visCal.month;
        default: busRdata = visCal.year;
      endcase
    end
  end

  // R11
  commit_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrHalt) |-> $past(strb.commit));

  initial begin
    if (HI_W < 1) $error("address too narrow");
  end

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import bcd_rtc_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter logic [5:0] RESET_CENT = 6'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata
);

  strobeT strb;
  calT    visCal;
  logic   run;

  bcd_rtc_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .visCal(visCal), .busRdata(busRdata), .strb(strb), .run(run)
  );

  bcd_rtc_datapath #(.RESET_CENT(RESET_CENT)) u_dp (
    .clk(clk), .rstN(rstN), .secTick(secTick), .run(run), .strb(strb), .visCal(visCal)
  );

endmodule

// File: tb/bcd_rtc_top_tb.sv
module bcd_rtc_top_tb;

  localparam logic [12:0] BASE = 13'h1FF8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [12:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  bcd_rtc_top u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wrA(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    wrA(BASE + 13'(off), d);
  endtask

  task automatic rdA(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [2:0] off, input logic [7:0] exp);
    logic [7:0] d;
    rdA(BASE + 13'(off), d);
    check(tag, d, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] ce, input logic [7:0] yr, input logic [7:0] mo,
                         input logic [7:0] dt, input logic [7:0] dy, input logic [7:0] hr,
                         input logic [7:0] mn, input logic [7:0] sc);
    wr(3'd0, 8'h80);
    wr(3'd1, sc);
    wr(3'd2, mn);
    wr(3'd3, hr);
    wr(3'd4, dy);
    wr(3'd5, dt);
    wr(3'd6, mo);
    wr(3'd7, yr);
    wr(3'd0, {2'b00, ce[5:0]});
  endtask

  task automatic expectDate(input string tag, input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] dt);
    expectReg({tag, " year"}, 3'd7, yr);
    expectReg({tag, " month"}, 3'd6, mo);
    expectReg({tag, " date"}, 3'd5, dt);
  endtask

  task automatic testReset();
    expectReg("R1 ctrl", 3'd0, 8'h20);
    expectReg("R1 sec", 3'd1, 8'h80);
    expectReg("R1 min", 3'd2, 8'h00);
    expectReg("R1 hour", 3'd3, 8'h00);
    expectReg("R1 day", 3'd4, 8'h01);
    expectDate("R1", 8'h00, 8'h01, 8'h01);
  endtask

  task automatic testOscStop();
    tick();
    expectReg("R2 stopped sec", 3'd1, 8'h80);
    wr(3'd1, 8'h00);
    tick();
    expectReg("R2 running sec", 3'd1, 8'h01);
    wr(3'd2, 8'h45);
    expectReg("R10 min ignored unheld", 3'd2, 8'h00);
    wr(3'd1, 8'h80);
    tick();
    expectReg("R2 restop sec", 3'd1, 8'h81);
    wr(3'd1, 8'h00);
  endtask

  task automatic testYearEnd();
    setTime(8'h20, 8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    expectReg("R11 loaded min", 3'd2, 8'h59);
    tick();
    expectReg("R3 sec wrap", 3'd1, 8'h00);
    expectReg("R3 min wrap", 3'd2, 8'h00);
    expectReg("R3 hour wrap", 3'd3, 8'h00);
    expectReg("R4 day 07->01", 3'd4, 8'h01);
    expectDate("R5 year end", 8'h24, 8'h01, 8'h01);
    expectReg("R5 century kept", 3'd0, 8'h20);
  endtask

  task automatic testMonths();
    setTime(8'h20, 8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    expectDate("R5 30-day month", 8'h23, 8'h05, 8'h01);
    expectReg("R4 day step", 3'd4, 8'h04);
    setTime(8'h20, 8'h23, 8'h05, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    expectDate("R5 31-day month", 8'h23, 8'h05, 8'h31);
    setTime(8'h20, 8'h23, 8'h09, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    expectDate("R5 Sept end", 8'h23, 8'h10, 8'h01);
  endtask

  task automatic febCase(input string tag, input logic [7:0] ce, input logic [7:0] yr,
                         input logic [7:0] dt, input logic [7:0] expMo, input logic [7:0] expDt);
    setTime(ce, yr, 8'h02, dt, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    expectDate(tag, yr, expMo, expDt);
  endtask

  task automatic testLeap();
    febCase("R6 yr24 28", 8'h20, 8'h24, 8'h28, 8'h02, 8'h29);
    febCase("R6 yr24 29", 8'h20, 8'h24, 8'h29, 8'h03, 8'h01);
    febCase("R6 yr23 28", 8'h20, 8'h23, 8'h28, 8'h03, 8'h01);
    febCase("R6 c20 yr00", 8'h20, 8'h00, 8'h28, 8'h02, 8'h29);
    febCase("R6 c19 yr00", 8'h19, 8'h00, 8'h28, 8'h03, 8'h01);
  endtask

  task automatic testCentury();
    setTime(8'h20, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    tick();
    expectDate("R7 year 99 wrap", 8'h00, 8'h01, 8'h01);
    expectReg("R7 century step", 3'd0, 8'h21);
  endtask

  task automatic testReadHold();
    setTime(8'h20, 8'h30, 8'h06, 8'h15, 8'h05, 8'h12, 8'h00, 8'h00);
    wr(3'd0, 8'h40);
    expectReg("R9 ctrl readback", 3'd0, 8'h60);
    tick(); tick(); tick();
    expectReg("R9 sec frozen", 3'd1, 8'h00);
    expectReg("R9 hour frozen", 3'd3, 8'h12);
    wr(3'd0, 8'h00);
    expectReg("R12 sec advanced", 3'd1, 8'h03);
  endtask

  task automatic testLoadHold();
    logic [7:0] d;
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h7F);
    expectReg("R10 raw min stored", 3'd2, 8'h7F);
    wrA(13'h1FF7, 8'h55);
    rdA(13'h1FF7, d);
    check("R8 outside read", d, 8'h00);
    expectReg("R8 year untouched", 3'd7, 8'h30);
    wr(3'd0, 8'h80 | 8'h22);
    expectReg("R10 century stored", 3'd0, 8'hA2);
    wr(3'd2, 8'h10);
    wr(3'd1, 8'h20);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = BASE; busWdata = 8'h20; secTick = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; secTick = 1'b0;
    expectReg("R11 tick dropped", 3'd1, 8'h20);
    expectReg("R11 commit min", 3'd2, 8'h10);
    expectReg("R11 commit century", 3'd0, 8'h20);
    tick();
    expectReg("R11 after commit", 3'd1, 8'h21);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOscStop();
    testYearEnd();
    testMonths();
    testLeap();
    testCentury();
    testReadHold();
    testLoadHold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule